// File: doc/BRIEF.md
# Serial Flash Programming Command Engine

This block is the slave side of an in-system programming port for a 4 KB on-chip code store. A host drives a three-wire serial link (clock, data in, data out) while holding a programming-mode input high. The engine deserializes fixed 4-byte instructions, decodes them into memory operations and shifts the answer back out. The operations are: arming the port, chip erase, byte read, byte write, 256-byte page read and page write, lock-bit write and read, and signature read.

The serial clock and data are brought into the system clock domain by a two-flop synchronizer with edge detection. Data in is taken on the serial clock rising edge and data out moves after the falling edge, MSB first in both directions. A behavioural code store sits under the engine. It models a self-timed byte write with data polling, a self-timed chip erase that sweeps the array to 0xFF, and three lock bits that can only be set in order. The serial clock must run slower than one sixteenth of the system clock.

Top module: `isp_cmd_engine`

## Requirements
- R1: While `isp_en` is low, `miso` is 0 and the armed state, the bit counter and the byte position are cleared. Lowering `isp_en` in the middle of an instruction aborts it, so the next instruction after `isp_en` rises again frames from its first byte.
- R2: For the first GUARD_CYC system clocks after `isp_en` rises, serial clock edges are ignored.
- R3: `mosi` is taken MSB first on each serial clock rising edge. `miso` changes only after a serial clock falling edge, and presents each response byte MSB first.
- R4: The bytes 0xAC, 0x53, x, x arm the port, and `miso` returns 0x69 during the fourth byte. Until the port is armed, every other instruction has no effect and returns 0x00.
- R5: An armed 0xAC whose second byte has bits [7:5] = 100 starts a chip erase lasting ERASE_CYC clocks. The erase sets every location to 0xFF and clears all lock bits. Memory reads during the erase return 0x00.
- R6: Byte read is 0x20, then a byte whose bits [3:0] are address bits 11..8, then address bits 7..0. The fourth byte returns the stored data. Bytes 1 to 3 of any instruction return 0x00.
- R7: Byte write is 0x40, with the same address layout as byte read and the data in the fourth byte. The stored byte becomes the old value AND the new value, so only an erase sets bits back to 1.
- R8: For WR_CYC clocks after a write, a read of that address returns the written data with bit 7 inverted.
- R9: Page read is 0x30 and page write is 0x50, followed by a byte whose bits [3:0] give the page. Exactly 256 data bytes follow, for offsets 0 to 255 in order. The next instruction is decoded right after the last data byte.
- R10: Lock write is 0xAC with a second byte of 111000 followed by two select bits. Select 01 sets LB1, 10 sets LB2 only if LB1 is already set, and 11 sets LB3 only if LB2 is already set. Lock read is 0x24, and its fourth byte returns {5'b0, LB3, LB2, LB1}, with a set bit read as 1.
- R11: With LB1 set, writes are ignored. With LB2 set, memory reads and signature reads return 0x00.
- R12: Signature read is 0x28. Bits [1:0] of the second byte select 0, 1 or 2, which return SIG0, SIG1 or SIG2. Selector 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| isp_en | input | 1 | Programming mode; the port is live only while high |
| sck | input | 1 | Serial clock from the host (asynchronous) |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial response data to the host |

## Verification
Some properties are checked by the assertions on every cycle. An abort always drops the armed and page states. No byte completes inside the guard window, and `miso` moves only after a detected falling edge. A page stays open for exactly 256 bytes. Lock bits never appear out of order. Page reads yield zero while an erase runs or LB2 is set. Other behaviour can only be shown by the bench's scenarios: the 0x69 acknowledge, the AND-only write semantics, polling inside the write window versus true data after it, the erase sweep to 0xFF, framing recovery after an abort, and signature selection and hiding.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam logic [7:0] OP_CTRL    = 8'hAC;
    localparam logic [7:0] ARM_KEY    = 8'h53;
    localparam logic [7:0] ARM_ACK    = 8'h69;
    localparam logic [7:0] OP_RD_BYTE = 8'h20;
    localparam logic [7:0] OP_WR_BYTE = 8'h40;
    localparam logic [7:0] OP_RD_PAGE = 8'h30;
    localparam logic [7:0] OP_WR_PAGE = 8'h50;
    localparam logic [7:0] OP_RD_LOCK = 8'h24;
    localparam logic [7:0] OP_RD_SIG  = 8'h28;

    // Position of the next header byte inside a 4-byte frame
    typedef enum logic [1:0] {
        POS_OP   = 2'd0,
        POS_HI   = 2'd1,
        POS_LO   = 2'd2,
        POS_DATA = 2'd3
    } frame_pos_e;

    typedef struct packed {
        logic lb3;
        logic lb2;
        logic lb1;
    } lock_t;

    function automatic logic is_erase(input logic [7:0] b);
        return b[7:5] == 3'b100;
    endfunction

    function automatic logic is_lock_wr(input logic [7:0] b);
        return b[7:2] == 6'b111000;
    endfunction

endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic mosi,
    output logic rise,
    output logic fall,
    output logic mosi_s
);
    logic [2:0] sck_q;
    logic [1:0] mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[1:0], sck};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign rise   = sck_q[1] & ~sck_q[2];
    assign fall   = ~sck_q[1] & sck_q[2];
    assign mosi_s = mosi_q[1];
endmodule

// File: rtl/isp_shift.sv
module isp_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       rise,
    input  logic       fall,
    input  logic       din,
    input  logic       load,
    input  logic [7:0] tx,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       miso
);
    logic [2:0] bit_cnt;
    logic [7:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bit_cnt   <= '0;
            rx_byte   <= '0;
            tx_sr     <= '0;
            byte_done <= 1'b0;
            miso      <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load) tx_sr <= tx;
            if (rise) begin
                rx_byte <= {rx_byte[6:0], din};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) byte_done <= 1'b1;
            end
            if (fall) miso <= tx_sr[3'd7 - bit_cnt];
        end
    end
endmodule

// File: rtl/isp_code_store.sv
module isp_code_store
    import isp_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WR_CYC    = 2000,
    parameter int ERASE_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_req,
    input  logic              lock_req,
    input  logic [1:0]        lock_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              erasing,
    output lock_t             locks
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WC_W  = $clog2(WR_CYC + 1);
    localparam int EC_W  = $clog2(ERASE_CYC + 1);

    logic [7:0]        mem [DEPTH];
    logic [EC_W-1:0]   er_cnt;
    logic [ADDR_W:0]   sweep;
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    logic [WC_W-1:0]   wr_cnt;
    logic              accept, commit, sweep_we;

    assign erasing  = er_cnt != '0;
    assign accept   = wr_req && !erasing && !erase_req && !locks.lb1;
    assign commit   = pend_v && (accept || wr_cnt == WC_W'(1));
    assign sweep_we = erasing && !sweep[ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            er_cnt    <= '0;
            sweep     <= '0;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            wr_cnt    <= '0;
            locks     <= '0;
        end else begin
            if (erase_req) begin
                er_cnt <= EC_W'(ERASE_CYC);
                sweep  <= '0;
                locks  <= '0;
            end else if (erasing) begin
                er_cnt <= er_cnt - EC_W'(1);
                if (sweep_we) sweep <= sweep + 1'b1;
            end

            if (erase_req) begin
                pend_v <= 1'b0;
            end else if (accept) begin
                pend_v    <= 1'b1;
                pend_addr <= wr_addr;
                pend_data <= wr_data;
                wr_cnt    <= WC_W'(WR_CYC);
            end else if (pend_v) begin
                wr_cnt <= wr_cnt - WC_W'(1);
                if (wr_cnt == WC_W'(1)) pend_v <= 1'b0;
            end

            if (lock_req && !erasing && !erase_req) begin
                case (lock_sel)
                    2'd1:    locks.lb1 <= 1'b1;
                    2'd2:    if (locks.lb1) locks.lb2 <= 1'b1;
                    2'd3:    if (locks.lb2) locks.lb3 <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Array: one write port, either the erase sweep or a write commit
    always_ff @(posedge clk) begin
        if (sweep_we)
            mem[sweep[ADDR_W-1:0]] <= 8'hFF;
        else if (commit)
            mem[pend_addr] <= mem[pend_addr] & pend_data;
    end

    always_comb begin
        if (pend_v && rd_addr == pend_addr)
            rd_data = {~pend_data[7], pend_data[6:0]};
        else
            rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/isp_cmd_engine.sv
module isp_cmd_engine
    import isp_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         WR_CYC    = 2000,
    parameter int         ERASE_CYC = 5000,
    parameter int         GUARD_CYC = 64,
    parameter logic [7:0] SIG0      = 8'hA5,
    parameter logic [7:0] SIG1      = 8'h5A,
    parameter logic [7:0] SIG2      = 8'h3C
) (
    input  logic clk,
    input  logic rst,
    input  logic isp_en,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int PG_W = ADDR_W - 8;
    localparam int GD_W = $clog2(GUARD_CYC + 1);
    localparam logic [GD_W-1:0] GUARD_LIM = GD_W'(GUARD_CYC);

    logic              clear;
    logic              sck_rise, sck_fall, mosi_s;
    logic              rise_ok, fall_ok;
    logic [GD_W-1:0]   guard_cnt;
    logic              guard_done;
    logic [7:0]        rx_byte;
    logic              byte_done;
    logic              load_q;
    logic [7:0]        tx_next;

    logic [7:0]        op, hi, lo;
    frame_pos_e        pos;
    logic              in_page;
    logic [7:0]        page_cnt;
    logic              enabled;

    logic              exec, wr_req, erase_req, lock_req;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        rd_data, mem_view;
    logic              erasing;
    lock_t             locks;

    assign clear = rst || !isp_en;

    isp_sck_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .sck    (sck),
        .mosi   (mosi),
        .rise   (sck_rise),
        .fall   (sck_fall),
        .mosi_s (mosi_s)
    );

    always_ff @(posedge clk) begin
        if (clear)
            guard_cnt <= '0;
        else if (guard_cnt != GUARD_LIM)
            guard_cnt <= guard_cnt + GD_W'(1);
    end

    assign guard_done = guard_cnt == GUARD_LIM;
    assign rise_ok    = sck_rise && guard_done;
    assign fall_ok    = sck_fall && guard_done;

    isp_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (!isp_en),
        .rise      (rise_ok),
        .fall      (fall_ok),
        .din       (mosi_s),
        .load      (load_q),
        .tx        (tx_next),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .miso      (miso)
    );

    // Frame tracking and arming
    always_ff @(posedge clk) begin
        if (clear) begin
            op       <= '0;
            hi       <= '0;
            lo       <= '0;
            pos      <= POS_OP;
            in_page  <= 1'b0;
            page_cnt <= '0;
            enabled  <= 1'b0;
            load_q   <= 1'b0;
        end else begin
            load_q <= byte_done;
            if (byte_done) begin
                if (in_page) begin
                    page_cnt <= page_cnt + 8'd1;
                    if (page_cnt == 8'hFF) in_page <= 1'b0;
                end else begin
                    case (pos)
                        POS_OP: begin
                            op  <= rx_byte;
                            pos <= POS_HI;
                        end
                        POS_HI: begin
                            hi <= rx_byte;
                            if (enabled && (op == OP_RD_PAGE || op == OP_WR_PAGE)) begin
                                in_page  <= 1'b1;
                                page_cnt <= '0;
                                pos      <= POS_OP;
                            end else begin
                                pos <= POS_LO;
                            end
                        end
                        POS_LO: begin
                            lo  <= rx_byte;
                            pos <= POS_DATA;
                        end
                        POS_DATA: begin
                            pos <= POS_OP;
                            if (op == OP_CTRL && hi == ARM_KEY) enabled <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // Requests to the store, one cycle wide
    assign exec      = byte_done && !in_page && pos == POS_DATA && enabled;
    assign erase_req = exec && op == OP_CTRL && is_erase(hi);
    assign lock_req  = exec && op == OP_CTRL && is_lock_wr(hi);
    assign wr_req    = (exec && op == OP_WR_BYTE) ||
                       (byte_done && in_page && op == OP_WR_PAGE);
    assign addr      = in_page ? {hi[PG_W-1:0], page_cnt} : {hi[PG_W-1:0], lo};

    isp_code_store #(
        .ADDR_W    (ADDR_W),
        .WR_CYC    (WR_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .wr_addr   (addr),
        .wr_data   (rx_byte),
        .erase_req (erase_req),
        .lock_req  (lock_req),
        .lock_sel  (hi[1:0]),
        .rd_addr   (addr),
        .rd_data   (rd_data),
        .erasing   (erasing),
        .locks     (locks)
    );

    assign mem_view = (erasing || locks.lb2) ? 8'h00 : rd_data;

    // Response for the byte slot that follows the one just completed
    always_comb begin
        tx_next = 8'h00;
        if (in_page) begin
            if (op == OP_RD_PAGE) tx_next = mem_view;
        end else if (pos == POS_DATA) begin
            if (op == OP_CTRL && hi == ARM_KEY) begin
                tx_next = ARM_ACK;
            end else if (enabled) begin
                case (op)
                    OP_RD_BYTE: tx_next = mem_view;
                    OP_RD_LOCK: tx_next = {5'b0, locks};
                    OP_RD_SIG: begin
                        if (!locks.lb2) begin
                            case (hi[1:0])
                                2'd0:    tx_next = SIG0;
                                2'd1:    tx_next = SIG1;
                                2'd2:    tx_next = SIG2;
                                default: tx_next = 8'h00;
                            endcase
                        end
                    end
                    default: tx_next = 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/isp_cmd_engine_chk.sv
module isp_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       isp_en,
    input logic       miso,
    input logic       enabled,
    input logic       guard_done,
    input logic       byte_done,
    input logic       fall_ok,
    input logic       in_page,
    input logic [7:0] page_cnt,
    input logic       load_q,
    input logic [7:0] tx_next,
    input logic       erasing,
    input logic [2:0] locks,
    input logic       wr_req,
    input logic       erase_req,
    input logic       lock_req
);
    AST_ABORT_DROPS_STATE: assert property (@(posedge clk) disable iff (rst)
        !isp_en |=> (!enabled && !in_page)); // R1

    AST_GUARD_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
        (isp_en && !guard_done) |=> !byte_done); // R2

    AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(miso) && isp_en && $past(isp_en)) |-> $past(fall_ok)); // R3

    AST_NO_OP_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> !(wr_req || erase_req || lock_req)); // R4

    AST_ERASE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (load_q && erasing && in_page) |-> tx_next == 8'h00); // R5

    AST_PAGE_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (isp_en && in_page && byte_done && page_cnt != 8'hFF) |=> in_page); // R9

    AST_PAGE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (in_page && byte_done && page_cnt == 8'hFF) |=> !in_page); // R9

    AST_LOCK_ORDER_LB2: assert property (@(posedge clk) disable iff (rst)
        locks[1] |-> locks[0]); // R10

    AST_LOCK_ORDER_LB3: assert property (@(posedge clk) disable iff (rst)
        locks[2] |-> locks[1]); // R10

    AST_LOCK_HIDES_DATA: assert property (@(posedge clk) disable iff (rst)
        (load_q && locks[1] && in_page) |-> tx_next == 8'h00); // R11
endmodule

bind isp_cmd_engine isp_cmd_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .isp_en     (isp_en),
    .miso       (miso),
    .enabled    (enabled),
    .guard_done (guard_done),
    .byte_done  (byte_done),
    .fall_ok    (fall_ok),
    .in_page    (in_page),
    .page_cnt   (page_cnt),
    .load_q     (load_q),
    .tx_next    (tx_next),
    .erasing    (erasing),
    .locks      (locks),
    .wr_req     (wr_req),
    .erase_req  (erase_req),
    .lock_req   (lock_req)
);

// File: tb/isp_cmd_engine_tb.sv
module isp_cmd_engine_tb;
    localparam int WR_CYC    = 2000;
    localparam int ERASE_CYC = 5000;
    localparam int HALF      = 10;
    localparam logic [7:0] SIG0 = 8'hA5, SIG1 = 8'h5A, SIG2 = 8'h3C;

    logic clk = 1'b0;
    logic rst, isp_en, sck, mosi;
    wire  miso;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] model_mem [4096];
    logic [2:0] model_lock;

    always #10 clk = ~clk;

    isp_cmd_engine #(
        .WR_CYC    (WR_CYC),
        .ERASE_CYC (ERASE_CYC),
        .SIG0 (SIG0), .SIG1 (SIG1), .SIG2 (SIG2)
    ) u_dut (
        .clk    (clk),
        .rst    (rst),
        .isp_en (isp_en),
        .sck    (sck),
        .mosi   (mosi),
        .miso   (miso)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            r[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic instr(input logic [7:0] b0, b1, b2, b3, output logic [7:0] r3);
        logic [7:0] r;
        xfer(b0, r);
        xfer(b1, r);
        xfer(b2, r);
        xfer(b3, r3);
    endtask

    task automatic open_session();
        isp_en = 1'b1;
        wait_clk(80);
    endtask

    task automatic close_session();
        isp_en = 1'b0;
        wait_clk(5);
    endtask

    function automatic logic [7:0] exp_read(input int a);
        return model_lock[1] ? 8'h00 : model_mem[a];
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        if (!model_lock[0]) model_mem[a] = model_mem[a] & d;
    endtask

    initial begin
        logic [7:0] r;
        rst = 1'b1; isp_en = 1'b0; sck = 1'b0; mosi = 1'b0;
        model_lock = 3'b000;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        check("R1 miso low after reset", {7'b0, miso}, 8'h00);

        // R2: two edges inside the guard window must not shift bits in
        isp_en = 1'b1;
        for (int i = 0; i < 2; i++) begin
            mosi = 1'b1; wait_clk(5); sck = 1'b1; wait_clk(5); sck = 1'b0;
        end
        wait_clk(80);
        instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R4 arm ack 0x69 with guarded edges R2", r, 8'h69);

        // R5: erase, read while busy, read after
        instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
        for (int a = 0; a < 4096; a++) model_mem[a] = 8'hFF;
        model_lock = 3'b000;
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R5 read during erase", r, 8'h00);
        wait_clk(ERASE_CYC);
        instr(8'h20, 8'h0F, 8'hFF, 8'h00, r);
        check("R5 erased location", r, exp_read(12'hFFF));

        // R1: abort mid-instruction, R4: unarmed instructions ignored
        xfer(8'hAC, r);
        xfer(8'h53, r);
        close_session();
        open_session();
        instr(8'h40, 8'h01, 8'h23, 8'h00, r);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R4 unarmed read returns zero", r, 8'h00);
        instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
        check("R1 framing restarts after abort", r, 8'h69);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R4 unarmed write had no effect", r, exp_read(12'h123));

        // R7/R8/R6: write, poll, settle, AND semantics
        instr(8'h40, 8'h01, 8'h23, 8'h3C, r);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R8 polling inverts bit 7", r, {~8'h3C >> 7, 7'h3C});
        model_write(12'h123, 8'h3C);
        wait_clk(WR_CYC + 50);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R6 byte read after write", r, exp_read(12'h123));
        instr(8'h40, 8'h01, 8'h23, 8'hF0, r);
        model_write(12'h123, 8'hF0);
        wait_clk(WR_CYC + 50);
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R7 write only clears bits", r, exp_read(12'h123));

        // R9: page write then page read of page 5
        xfer(8'h50, r);
        xfer(8'h05, r);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            d = 8'((i * 7 + 3) ^ (i >> 3));
            xfer(d, r);
            model_write(12'h500 + i, d);
        end
        xfer(8'h30, r);
        xfer(8'h05, r);
        for (int i = 0; i < 256; i++) begin
            xfer(8'h00, r);
            check("R9 page read byte", r, exp_read(12'h500 + i));
        end
        instr(8'h20, 8'h05, 8'hFF, 8'h00, r);
        check("R9 next instruction after page", r, exp_read(12'h5FF));

        // R12: signatures
        instr(8'h28, 8'h00, 8'h00, 8'h00, r);
        check("R12 signature 0", r, SIG0);
        instr(8'h28, 8'h01, 8'h00, 8'h00, r);
        check("R12 signature 1", r, SIG1);
        instr(8'h28, 8'h02, 8'h00, 8'h00, r);
        check("R12 signature 2", r, SIG2);
        instr(8'h28, 8'h03, 8'h00, 8'h00, r);
        check("R12 signature selector 3", r, 8'h00);

        // R10/R11: lock ordering and effects
        instr(8'hAC, 8'hE2, 8'h00, 8'h00, r);
        instr(8'hAC, 8'hE3, 8'h00, 8'h00, r);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R10 out-of-order lock ignored", r, {5'b0, model_lock});
        instr(8'hAC, 8'hE1, 8'h00, 8'h00, r);
        model_lock[0] = 1'b1;
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R10 LB1 set", r, {5'b0, model_lock});
        instr(8'h40, 8'h02, 8'h00, 8'h00, r);
        model_write(12'h200, 8'h00);
        wait_clk(WR_CYC + 50);
        instr(8'h20, 8'h02, 8'h00, 8'h00, r);
        check("R11 write blocked by LB1", r, exp_read(12'h200));
        instr(8'hAC, 8'hE2, 8'h00, 8'h00, r);
        model_lock[1] = 1'b1;
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R10 LB2 after LB1", r, {5'b0, model_lock});
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R11 read hidden by LB2", r, exp_read(12'h123));
        instr(8'h28, 8'h00, 8'h00, 8'h00, r);
        check("R11 signature hidden by LB2", r, 8'h00);
        instr(8'hAC, 8'hE3, 8'h00, 8'h00, r);
        model_lock[2] = 1'b1;
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R10 LB3 after LB2", r, {5'b0, model_lock});

        // R5: erase clears the lock bits too
        instr(8'hAC, 8'h80, 8'h00, 8'h00, r);
        for (int a = 0; a < 4096; a++) model_mem[a] = 8'hFF;
        model_lock = 3'b000;
        wait_clk(ERASE_CYC + 20);
        instr(8'h24, 8'h00, 8'h00, 8'h00, r);
        check("R5 erase clears locks", r, {5'b0, model_lock});
        instr(8'h20, 8'h01, 8'h23, 8'h00, r);
        check("R5 erase restores 0xFF", r, exp_read(12'h123));

        close_session();
        check("R1 miso low when inactive", {7'b0, miso}, 8'h00);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end
endmodule